// File: doc/BRIEF.md
# Interleaved Bitstream Counting Decimator

This block turns a one-bit oversampled bitstream into multi-bit samples by counting the ones it sees over a window of `WIN` clock cycles. The block has `NCNT` such counters. They all read the same bitstream bit on the same clock. Their windows are offset from each other by `WIN/NCNT` cycles, so one of them finishes every `WIN/NCNT` cycles. Each finished total is placed on a single output port with a valid strobe and the number of the counter that produced it. The merged stream therefore carries `NCNT` samples per window rather than one.

Only cycles with the enable high count as time for the block. A low enable freezes the window phase and every running total. Because the same bit reaches every counter and the counters are plain digital logic, all counters produce the same value for the same input density. No gain or offset differs from one counter to another.

Top module: `interleaved_count_decim`

## Requirements
- R1: Each valid output sample equals the number of ones on `bit_in` over the `WIN` enabled cycles that immediately precede the cycle on which that counter's window closes.
- R2: The sample word is `$clog2(WIN)+1` bits wide. A window in which every bit is one reports exactly `WIN`, with no wraparound.
- R3: The enabled cycles are numbered from 0 starting at reset. Counter k's window closes on every enabled cycle whose number modulo `WIN` equals `k*WIN/NCNT`. The sample from that counter carries `out_idx` = k.
- R4: Once every counter has started, valid samples arrive with `out_idx` running 0, 1, …, `NCNT-1` and then wrapping back to 0. This gives one sample per `WIN/NCNT` enabled cycles.
- R5: A counter emits nothing until it has completed one full window. The first valid sample after reset follows enabled cycle number `WIN`.
- R6: On a closing cycle, that cycle's bit goes to the new window and not to the old one. No enabled cycle is skipped or counted twice between consecutive windows.
- R7: While `en` is low, the phase and all totals hold their values and `out_valid` is low one cycle later.
- R8: A synchronous reset clears `out_valid`, `out_data` and `out_idx` to 0 and restarts the window phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bitstream clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Counts this cycle when high; holds all state when low |
| bit_in | input | 1 | One-bit modulator output |
| out_data | output | $clog2(WIN)+1 | Ones count of the finished window |
| out_valid | output | 1 | High for one cycle per emitted sample |
| out_idx | output | max(1,$clog2(NCNT)) | Counter that produced the sample |

## Verification
Two things happen on the same edge when a window closes: one counter hands over its finished total, and it takes that cycle's bit as the first count of its next window. The bench makes this case happen often by using densities where boundary bits alternate between 0 and 1, and by running an all-ones stretch. A bit assigned to the wrong window would then give a count that is one too high or one too low. A behavioural model keeps a sliding history of the enabled-cycle bits and predicts every sample, and the comparison runs on every cycle. Gaps in the enable that fall on closing cycles test the second collision: a hold arriving in the same cycle as a handover.

// File: rtl/interleaved_count_decim.sv
module interleaved_count_decim #(
  parameter int WIN  = 64,
  parameter int NCNT = 2,
  localparam int OW  = $clog2(WIN) + 1,
  localparam int IW  = (NCNT > 1) ? $clog2(NCNT) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          bit_in,
  output logic [OW-1:0] out_data,
  output logic          out_valid,
  output logic [IW-1:0] out_idx
);
  localparam int STEP = WIN / NCNT;
  localparam int PW   = $clog2(WIN);

  logic [PW-1:0]   ph;
  logic [NCNT-1:0] hit;
  logic [NCNT-1:0] primed;
  logic [OW-1:0]   acc [NCNT];
  logic [OW-1:0]   sel_data;
  logic [IW-1:0]   sel_idx;
  logic            sel_ok;

  always_comb begin
    sel_data = '0;
    sel_idx  = '0;
    sel_ok   = 1'b0;
    for (int k = 0; k < NCNT; k++) begin
      hit[k] = (ph == PW'(k * STEP));
      if (hit[k]) begin
        sel_data = acc[k];
        sel_idx  = IW'(k);
        sel_ok   = primed[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      primed <= '0;
      for (int k = 0; k < NCNT; k++) acc[k] <= '0;
    end else if (en) begin
      ph <= (ph == PW'(WIN - 1)) ? '0 : ph + 1'b1;
      for (int k = 0; k < NCNT; k++) begin
        if (hit[k]) begin
          acc[k]    <= OW'(bit_in);
          primed[k] <= 1'b1;
        end else begin
          acc[k] <= acc[k] + OW'(bit_in);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_idx   <= '0;
    end else begin
      out_valid <= en & sel_ok;
      if (en & sel_ok) begin
        out_data <= sel_data;
        out_idx  <= sel_idx;
      end
    end
  end
endmodule

// File: rtl/icd_chk.sv
module icd_chk #(
  parameter int WIN = 64,
  parameter int NCNT = 2,
  parameter int OW = 7,
  parameter int IW = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [OW-1:0] out_data,
  input logic          out_valid,
  input logic [IW-1:0] out_idx
);
  localparam int EW = $clog2(WIN + 2);

  logic [EW-1:0] ecnt;
  logic [IW-1:0] last_idx;
  logic          seen;
  logic [IW-1:0] next_idx;

  assign next_idx = (last_idx == IW'(NCNT - 1)) ? '0 : last_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ecnt     <= '0;
      last_idx <= '0;
      seen     <= 1'b0;
    end else begin
      if (en && ecnt != EW'(WIN + 1)) ecnt <= ecnt + 1'b1;
      if (out_valid) begin
        last_idx <= out_idx;
        seen     <= 1'b1;
      end
    end
  end

  // R2
  count_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_data <= OW'(WIN));

  // R4
  idx_order_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && seen) |-> out_idx == next_idx);

  // R5
  full_window_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ecnt == EW'(WIN + 1));

  // R7
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !out_valid);

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0 && out_idx == '0));
endmodule

bind interleaved_count_decim icd_chk #(.WIN(WIN), .NCNT(NCNT), .OW(OW), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .out_data(out_data),
  .out_valid(out_valid), .out_idx(out_idx)
);

// File: tb/interleaved_count_decim_tb.sv
module interleaved_count_decim_tb;
  localparam int WIN  = 64;
  localparam int NCNT = 2;
  localparam int STEP = WIN / NCNT;
  localparam int OW   = $clog2(WIN) + 1;
  localparam int IW   = (NCNT > 1) ? $clog2(NCNT) : 1;

  logic clk = 0;
  logic rst = 1;
  logic en = 0;
  logic bit_in = 0;
  logic [OW-1:0] out_data;
  logic          out_valid;
  logic [IW-1:0] out_idx;

  always #10 clk = ~clk;

  interleaved_count_decim #(.WIN(WIN), .NCNT(NCNT)) u_dut (
    .clk(clk), .rst(rst), .en(en), .bit_in(bit_in),
    .out_data(out_data), .out_valid(out_valid), .out_idx(out_idx)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit started = 0;

  int hist[$];
  int n_en = 0;
  int sd_acc = 0;
  bit exp_rst = 1;
  bit exp_valid = 0;
  int exp_data = 0;
  int exp_idx = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic e, input int dens);
    int s;
    logic b;
    @(negedge clk);
    if (started) begin
      if (exp_rst) begin
        check(out_valid == 1'b0, "R8 valid", int'(out_valid), 0);
        check(out_data == '0, "R8 data", int'(out_data), 0);
        check(out_idx == '0, "R8 idx", int'(out_idx), 0);
      end else begin
        check(out_valid == exp_valid, "R5 R7 valid", int'(out_valid), int'(exp_valid));
        if (exp_valid && out_valid) begin
          check(int'(out_data) == exp_data, "R1 R2 R6 data", int'(out_data), exp_data);
          check(int'(out_idx) == exp_idx, "R3 R4 idx", int'(out_idx), exp_idx);
        end
      end
    end
    started = 1;
    sd_acc += dens;
    if (sd_acc >= 256) begin b = 1; sd_acc -= 256; end else b = 0;
    rst = r; en = e; bit_in = b;
    if (r) begin
      hist.delete();
      n_en = 0;
      exp_rst = 1;
      exp_valid = 0;
    end else begin
      exp_rst = 0;
      exp_valid = 0;
      if (e) begin
        if ((n_en % STEP) == 0 && n_en >= WIN) begin
          s = 0;
          foreach (hist[i]) s += hist[i];
          exp_valid = 1;
          exp_data = s;
          exp_idx = (n_en % WIN) / STEP;
        end
        hist.push_back(int'(b));
        if (hist.size() > WIN) void'(hist.pop_front());
        n_en++;
      end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) step(1, 0, 0);
    for (int i = 0; i < 400; i++) step(0, 1, 96);
    for (int i = 0; i < 400; i++) step(0, !((i % 37) == 5 || (i % 53) < 3), 96);
    for (int i = 0; i < 200; i++) step(0, 1, 256);
    for (int i = 0; i < 200; i++) step(0, 1, 0);
    for (int i = 0; i < 200; i++) step(0, (i % 32) != 0, 128);
    for (int i = 0; i < 2048; i++) step(0, !((i % 41) == 7), i / 8);
    for (int i = 0; i < 3; i++) step(1, 1, 200);
    for (int i = 0; i < 300; i++) step(0, 1, 200);
    step(0, 0, 0);
    finish_run();
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule